// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical frame after a translation buffer miss. A walk starts when the walker is idle and a request arrives. The walker reads a directory entry at an address built from the directory base and the top ten address bits. It then reads a table entry at an address built from the frame field of the directory entry and the next ten address bits. Every table and every page is 4 KB.

Each entry it uses has its Accessed flag set. When that flag is clear, the entry is written back with the flag set before the walk moves on. A walk ends in one of two ways. It can end in a fill pulse, which carries the virtual page number, the frame and the low attribute bits of the final entry. It can also end in a fault pulse, when either level has a clear Present flag. In that case the faulting address and the level stay held on dedicated outputs. Only one walk is in flight at a time.

Memory is reached through one request/acknowledge port. A request and its address, direction and write data stay fixed until acknowledge. Read data is valid in the cycle of the acknowledge.

Top module: `ptw_top`

## Requirements
- R1: After reset, busy, mem_req, fill_valid and fault_valid are 0, and fault_vaddr is 0.
- R2: The first access of a walk is a read at {dir_base, va[31:22], 2'b00}. Here dir_base is the 20-bit frame sampled in the cycle the request is accepted.
- R3: The table entry read is at {pde[31:12], va[21:12], 2'b00}, where pde is the directory entry read in the same walk.
- R4: A directory entry with bit 0 (Present) equal to 0 ends the walk with fault_level=0. No table read and no write are made.
- R5: A table entry with bit 0 equal to 0 ends the walk with fault_level=1, and that entry is not written.
- R6: An entry used with bit 5 (Accessed) equal to 0 is written back to its own address with bit 5 set and all other bits unchanged. This happens right after its read. An entry that already has bit 5 set is not written.
- R7: On success, fill_vpn=va[31:12], fill_frame=pte[31:12] and fill_attr=pte[11:0] with bit 5 forced to 1. Bit 0 of fill_attr is thus 1.
- R8: On a fault, fault_vaddr takes the full virtual address of the walk. It changes at no other time.
- R9: A request is accepted only when busy is 0. busy is 1 from the cycle after acceptance through the result cycle. A request raised while busy is ignored.
- R10: fill_valid and fault_valid are one-cycle pulses, never high together, and busy is 0 in the cycle after either.
- R11: While mem_req is 1 and mem_ack is 0, mem_req, mem_addr, mem_we and mem_wdata hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_base | input | 20 | Frame number of the page directory (control register) |
| req_valid | input | 1 | Walk request |
| req_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | A walk is in flight |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write data (entry with Accessed set) |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| fill_valid | output | 1 | Translation result pulse |
| fill_vpn | output | 20 | Virtual page number of the result |
| fill_frame | output | 20 | Physical frame of the result |
| fill_attr | output | 12 | Low attribute bits of the final entry |
| fault_valid | output | 1 | Page fault pulse |
| fault_level | output | 1 | 0 = directory, 1 = table (held) |
| fault_vaddr | output | 32 | Faulting virtual address (held) |

## Verification
The hardest situation to reach from the ports is an Accessed write-back that appears only in memory. Such a write leaves the fill outputs untouched. The bench's memory model therefore checks each access against a predicted sequence as it happens. It also walks the same address twice, so that the second walk must skip both writes that the first walk made. A second hard situation is a request and a changed directory base that arrive mid-walk. These are injected while busy, and the access sequence must still match the first request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int LEVELS  = 2;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int PAD_W   = ADDR_W - FRAME_W - IDX_W;
  localparam int BIT_PRESENT  = 0;
  localparam int BIT_ACCESSED = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_WR_DIR, S_RD_TBL, S_WR_TBL, S_FILL, S_FAULT
  } walk_state_e;

  function automatic logic [ADDR_W-1:0] entry_addr(
    input logic [FRAME_W-1:0] base, input logic [IDX_W-1:0] idx);
    return {base, idx, {PAD_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] mark_accessed(input logic [ADDR_W-1:0] ent);
    logic [ADDR_W-1:0] r;
    r = ent;
    r[BIT_ACCESSED] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ptw_index_slicer.sv
module ptw_index_slicer
  import ptw_pkg::*;
#(
  parameter int N_LVL = LEVELS,
  parameter int I_W   = IDX_W,
  parameter int A_W   = ADDR_W
) (
  input  logic [A_W-1:0]            vaddr,
  output logic [N_LVL-1:0][I_W-1:0] idx
);
  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    assign idx[g] = vaddr[A_W-1-g*I_W -: I_W];
  end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0]  ent,
  output logic               present,
  output logic               accessed,
  output logic [FRAME_W-1:0] frame
);
  assign present  = ent[BIT_PRESENT];
  assign accessed = ent[BIT_ACCESSED];
  assign frame    = ent[ADDR_W-1:OFF_W];
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [FRAME_W-1:0]        dir_base,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_vaddr,
  input  logic [LEVELS-1:0][IDX_W-1:0] idx,
  input  logic                      rd_present,
  input  logic                      rd_accessed,
  input  logic [FRAME_W-1:0]        rd_frame,
  output logic [ADDR_W-1:0]         va_q,
  output logic                      busy,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [ADDR_W-1:0]         mem_wdata,
  input  logic                      mem_ack,
  input  logic [ADDR_W-1:0]         mem_rdata,
  output logic                      fill_valid,
  output logic [FRAME_W-1:0]        fill_vpn,
  output logic [FRAME_W-1:0]        fill_frame,
  output logic [OFF_W-1:0]          fill_attr,
  output logic                      fault_valid,
  output logic                      fault_level,
  output logic [ADDR_W-1:0]         fault_vaddr
);
  walk_state_e state;
  logic [FRAME_W-1:0] base_q, tbl_q;
  logic [ADDR_W-1:0]  ent_q;
  logic               done_access;
  logic [ADDR_W-1:0]  ent_marked;

  assign done_access = mem_req && mem_ack;
  assign ent_marked  = mark_accessed(ent_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      tbl_q       <= '0;
      ent_q       <= '0;
      fault_vaddr <= '0;
      fault_level <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          base_q <= dir_base;
          state  <= S_RD_DIR;
        end
        S_RD_DIR: if (done_access) begin
          ent_q <= mem_rdata;
          tbl_q <= rd_frame;
          if (!rd_present) begin
            fault_vaddr <= va_q;
            fault_level <= 1'b0;
            state       <= S_FAULT;
          end else if (!rd_accessed) state <= S_WR_DIR;
          else                       state <= S_RD_TBL;
        end
        S_WR_DIR: if (done_access) state <= S_RD_TBL;
        S_RD_TBL: if (done_access) begin
          ent_q <= mem_rdata;
          if (!rd_present) begin
            fault_vaddr <= va_q;
            fault_level <= 1'b1;
            state       <= S_FAULT;
          end else if (!rd_accessed) state <= S_WR_TBL;
          else                       state <= S_FILL;
        end
        S_WR_TBL: if (done_access) state <= S_FILL;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_RD_DIR: begin mem_req = 1'b1; mem_addr = entry_addr(base_q, idx[0]); end
      S_WR_DIR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = entry_addr(base_q, idx[0]); mem_wdata = ent_marked;
      end
      S_RD_TBL: begin mem_req = 1'b1; mem_addr = entry_addr(tbl_q, idx[1]); end
      S_WR_TBL: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = entry_addr(tbl_q, idx[1]); mem_wdata = ent_marked;
      end
      default: ;
    endcase
  end

  assign busy        = (state != S_IDLE);
  assign fill_valid  = (state == S_FILL);
  assign fault_valid = (state == S_FAULT);
  assign fill_vpn    = va_q[ADDR_W-1:OFF_W];
  assign fill_frame  = ent_q[ADDR_W-1:OFF_W];
  assign fill_attr   = ent_marked[OFF_W-1:0];

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_result_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fault_valid));
  p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || fault_valid) |=> !fill_valid && !fault_valid && !busy);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fill_valid && !fault_valid |=> busy);
  p_fault_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !mem_req);
  p_wb_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[BIT_ACCESSED]);
  p_fault_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_vaddr) |-> fault_valid);
  p_fill_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> fill_attr[BIT_PRESENT] && fill_attr[BIT_ACCESSED]);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] dir_base,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_vaddr,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ADDR_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [ADDR_W-1:0]  mem_rdata,
  output logic               fill_valid,
  output logic [FRAME_W-1:0] fill_vpn,
  output logic [FRAME_W-1:0] fill_frame,
  output logic [OFF_W-1:0]   fill_attr,
  output logic               fault_valid,
  output logic               fault_level,
  output logic [ADDR_W-1:0]  fault_vaddr
);
  logic [ADDR_W-1:0]            va_q;
  logic [LEVELS-1:0][IDX_W-1:0] idx;
  logic                         rd_present, rd_accessed;
  logic [FRAME_W-1:0]           rd_frame;

  ptw_index_slicer i_slicer (.vaddr(va_q), .idx(idx));

  ptw_entry_decode i_decode (
    .ent(mem_rdata), .present(rd_present), .accessed(rd_accessed), .frame(rd_frame));

  ptw_walk_fsm i_fsm (
    .clk, .rst_n, .dir_base, .req_valid, .req_vaddr, .idx,
    .rd_present, .rd_accessed, .rd_frame, .va_q, .busy,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .fill_valid, .fill_vpn, .fill_frame, .fill_attr,
    .fault_valid, .fault_level, .fault_vaddr);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy && !mem_req);
endmodule

// File: tb/test_ptw_top.sv
module test_ptw_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] dir_base = '0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic busy, mem_req, mem_we, mem_ack, fill_valid, fault_valid, fault_level;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, fault_vaddr;
  logic [19:0] fill_vpn, fill_frame;
  logic [11:0] fill_attr;

  always #4 clk = ~clk;

  ptw_top i_ptw_top (.*);

  int errors = 0, checks = 0, cycles = 0, lat = 0, wait_cnt = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] q_addr[$], q_wd[$];
  bit          q_we[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // memory responder: checks every access against the predicted sequence
  initial begin mem_ack = 1'b0; mem_rdata = '0; end
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        mem_ack = 1'b1;
        if (q_addr.size() == 0)
          chk(0, "R4/R5", "unexpected access", mem_addr, 32'hx);
        else begin
          logic [31:0] ea, ew; bit ewe;
          ea = q_addr.pop_front(); ewe = q_we.pop_front(); ew = q_wd.pop_front();
          chk(mem_addr == ea, "R2/R3", "access address", mem_addr, ea);
          chk(mem_we == ewe, "R6", "access direction", {31'b0, mem_we}, {31'b0, ewe});
          if (ewe) chk(mem_wdata == ew, "R6", "write data", mem_wdata, ew);
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = rd(mem_addr);
      end else wait_cnt++;
    end
  end

  task automatic push(input logic [31:0] a, input bit we, input logic [31:0] d);
    q_addr.push_back(a); q_we.push_back(we); q_wd.push_back(d);
  endtask

  task automatic run_walk(input logic [31:0] va, input logic [19:0] base,
                          input int latency, input bit spur);
    logic [31:0] pa, pde, ta, pte;
    bit efault, elvl;
    logic [31:0] old_fva;
    int n;
    pa = {base, va[31:22], 2'b00}; pde = rd(pa);
    push(pa, 0, 0);
    efault = 0; elvl = 0; pte = 0;
    if (!pde[0]) efault = 1;
    else begin
      if (!pde[5]) push(pa, 1, pde | 32'h20);
      ta = {pde[31:12], va[21:12], 2'b00}; pte = rd(ta);
      push(ta, 0, 0);
      if (!pte[0]) begin efault = 1; elvl = 1; end
      else if (!pte[5]) push(ta, 1, pte | 32'h20);
    end
    old_fva = fault_vaddr;
    lat = latency;
    dir_base = base; req_vaddr = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", {31'b0, busy}, 32'h1);
    if (spur) begin
      req_valid = 1'b1; req_vaddr = ~va; dir_base = ~base;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!(fill_valid || fault_valid) && n < 2000) begin @(negedge clk); n++; end
    chk(!(fill_valid && fault_valid), "R10", "exclusive result", {31'b0, fill_valid}, 32'h0);
    chk(fault_valid == efault, "R4/R5", "fault outcome", {31'b0, fault_valid}, {31'b0, efault});
    chk(busy == 1'b1, "R9", "busy in result cycle", {31'b0, busy}, 32'h1);
    if (efault) begin
      chk(fault_level == elvl, elvl ? "R5" : "R4", "fault level",
          {31'b0, fault_level}, {31'b0, elvl});
      chk(fault_vaddr == va, "R8", "fault address", fault_vaddr, va);
    end else begin
      chk(fill_valid, "R7", "fill pulse", {31'b0, fill_valid}, 32'h1);
      chk(fill_vpn == va[31:12], "R7", "fill vpn", {12'b0, fill_vpn}, {12'b0, va[31:12]});
      chk(fill_frame == pte[31:12], "R7", "fill frame", {12'b0, fill_frame}, {12'b0, pte[31:12]});
      chk(fill_attr == (pte[11:0] | 12'h020), "R7", "fill attr",
          {20'b0, fill_attr}, {20'b0, pte[11:0] | 12'h020});
      chk(fault_vaddr == old_fva, "R8", "fault address held", fault_vaddr, old_fva);
    end
    @(negedge clk);
    chk(!fill_valid && !fault_valid, "R10", "pulse width", {30'b0, fill_valid, fault_valid}, 32'h0);
    chk(busy == 1'b0, "R10", "idle after result", {31'b0, busy}, 32'h0);
    chk(q_addr.size() == 0, "R4/R5/R6", "missing accesses", q_addr.size(), 32'h0);
    q_addr.delete(); q_we.delete(); q_wd.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !mem_req && !fill_valid && !fault_valid, "R1", "idle outputs",
        {28'b0, busy, mem_req, fill_valid, fault_valid}, 32'h0);
    chk(fault_vaddr == 32'h0, "R1", "fault address", fault_vaddr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // directory at frame 0x00010, tables at 0x00020 / 0x00030
    mem[{20'h00010, 10'h001, 2'b00}] = {20'h00020, 12'h007};         // A clear
    mem[{20'h00020, 10'h003, 2'b00}] = {20'hABCDE, 12'h01B};         // A clear
    mem[{20'h00010, 10'h002, 2'b00}] = {20'h00030, 12'h027};         // A set
    mem[{20'h00030, 10'h004, 2'b00}] = {20'h12345, 12'hE06};         // not present
    mem[{20'h00030, 10'h005, 2'b00}] = {20'h0F0F0, 12'hFFF};         // all set
    mem[{20'h00010, 10'h3FF, 2'b00}] = {20'h00040, 12'h001};
    mem[{20'h00040, 10'h3FF, 2'b00}] = {20'hFFFFF, 12'h241};
    mem[{20'h00050, 10'h000, 2'b00}] = {20'h00060, 12'h021};
    mem[{20'h00060, 10'h000, 2'b00}] = {20'h00001, 12'h001};

    run_walk({10'h001, 10'h003, 12'h5A4}, 20'h00010, 0, 0); // R2/R3/R6 two writes
    run_walk({10'h001, 10'h003, 12'h000}, 20'h00010, 2, 0); // R6 no writes now
    run_walk({10'h00F, 10'h003, 12'h123}, 20'h00010, 1, 0); // R4 directory fault
    run_walk({10'h002, 10'h004, 12'hFFC}, 20'h00010, 3, 0); // R5 table fault
    run_walk({10'h002, 10'h005, 12'h010}, 20'h00010, 0, 1); // R8 held, R9 spur
    run_walk(32'hFFFFFFFF, 20'h00010, 1, 1);                // top index, R9
    run_walk(32'h00000000, 20'h00050, 0, 0);                // bottom index
    run_walk(32'h00000ABC, 20'h00077, 4, 1);                // R4 empty directory
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule